// File: doc/BRIEF.md
# Underflow-Decimating Interrupt Counter

This block thins a stream of carrier-period underflow pulses from a base timer into a periodic interrupt request. Software stores a reload value n through a small valid/ready write port while the function is off. Raising the function enable arms the counter. The first request then fires after n-1 counted events, and each later request fires after n counted events.

A mode bit selects what counts as an event. In the basic mode every underflow pulse counts. In the alternate mode a gating bit can replace underflows with edges of a companion timer's reload control signal. An edge-select bit then picks the rising or the falling edge. Edges are found against a copy of that signal registered one cycle earlier. The request is a registered one-cycle pulse.

The reload write port follows valid/ready rules. A write is taken on a clock edge where `cfg_wr_valid` and `cfg_wr_ready` are both high. `cfg_wr_ready` is high exactly while `func_en` is low, so a writer holding valid while the function runs is back-pressured until the function is switched off. Data must stay stable while valid is high and ready is low.

Top module: `uflow_decim_irq`

## Requirements
- R1: After reset `irq` is 0, `cfg_wr_ready` is 1 while `func_en` is 0, and the stored reload value is 1, so arming without a write gives one request per counted event.
- R2: A reload write takes effect only on an edge where `cfg_wr_valid` and `cfg_wr_ready` are both 1; `cfg_wr_ready` is 0 while `func_en` is 1, and an offered write during that time leaves the interrupt period unchanged.
- R3: With `mode_alt` = 0, every cycle with `uflow` = 1 is a counted event, whatever `gate_en` and `edge_fall` hold, and `reload_ctl` has no effect.
- R4: With `mode_alt` = 1 and `gate_en` = 0, every cycle with `uflow` = 1 is a counted event.
- R5: With `mode_alt` = 1, `gate_en` = 1 and `edge_fall` = 0, a counted event is a cycle where `reload_ctl` is 1 and was 0 in the previous cycle; `uflow` is ignored.
- R6: With `mode_alt` = 1, `gate_en` = 1 and `edge_fall` = 1, a counted event is a cycle where `reload_ctl` is 0 and was 1 in the previous cycle.
- R7: With a stored reload value n of 2 or more, the first request fires on the (n-1)th counted event after arming, and every later request fires n counted events after the previous one.
- R8: A stored reload value of 1 gives a request on every counted event; a value of 0 behaves exactly as 1.
- R9: Arming happens on the first edge where `func_en` is 1 after being 0; an event in that cycle is not counted. While `func_en` is 0 nothing is counted and `irq` stays 0. Re-arming restarts the first-period rule.
- R10: `irq` is high for the single cycle after the clock edge that samples the request-producing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Function enable; its rising level arms the counter |
| mode_alt | input | 1 | 0: basic mode, 1: alternate mode |
| gate_en | input | 1 | Alternate mode: count reload-signal edges instead of underflows |
| edge_fall | input | 1 | 0: rising edge counts, 1: falling edge counts |
| uflow | input | 1 | One-cycle underflow pulse from the base timer |
| reload_ctl | input | 1 | Companion timer reload control signal |
| cfg_wr_valid | input | 1 | Reload write offered |
| cfg_wr_ready | output | 1 | Reload write can be taken (function disabled) |
| cfg_wr_data | input | CNT_W | Reload value n |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `reload_ctl` is a level sampled on the clock. They also assume that the mode, gating and edge bits are only moved while the function is disabled, so no event qualification changes inside a period. They assume reset is held for at least one clock, so the registered reload-signal copy holds a real sample when checking starts. The stimulus changes configuration only in cycles where `func_en` is low. It drives every input half a period away from the sampling edge, and it keeps `reload_ctl` a clean level that toggles no faster than once per cycle.

// File: rtl/uflow_decim_pkg.sv
package uflow_decim_pkg;
  typedef enum logic [1:0] {
    SRC_UFLOW = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2
  } evt_src_e;

  function automatic evt_src_e pick_src(input logic alt, input logic gate, input logic fall);
    if (alt && gate) return fall ? SRC_FALL : SRC_RISE;
    return SRC_UFLOW;
  endfunction
endpackage

// File: rtl/uflow_evt_qual.sv
module uflow_evt_qual
  import uflow_decim_pkg::*;
(
  input  logic clk,
  input  logic mode_alt,
  input  logic gate_en,
  input  logic edge_fall,
  input  logic uflow,
  input  logic reload_ctl,
  output logic count_evt
);
  logic     ctl_q;
  evt_src_e src;

  // plain sampling register; it holds a valid copy after one clock in reset
  always_ff @(posedge clk) ctl_q <= reload_ctl;

  always_comb begin
    src = pick_src(mode_alt, gate_en, edge_fall);
    unique case (src)
      SRC_RISE: count_evt = reload_ctl & ~ctl_q;
      SRC_FALL: count_evt = ~reload_ctl & ctl_q;
      default:  count_evt = uflow;
    endcase
  end
endmodule

// File: rtl/uflow_reload_reg.sv
module uflow_reload_reg #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_RELOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload_q
);
  assign wr_ready = ~func_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                   reload_q <= CNT_W'(RST_RELOAD);
    else if (wr_valid && wr_ready) reload_q <= wr_data;
  end
endmodule

// File: rtl/uflow_decim_core.sv
module uflow_decim_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             count_evt,
  input  logic [CNT_W-1:0] reload_q,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             en_q;
  logic             arm;
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W-1:0] cnt;

  assign arm   = func_en & ~en_q;
  assign n_eff = (reload_q == '0) ? ONE : reload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= func_en;
      irq  <= 1'b0;
      if (arm) begin
        cnt <= n_eff - ONE;
      end else if (func_en && count_evt) begin
        if (cnt <= ONE) begin
          irq <= 1'b1;
          cnt <= n_eff;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/uflow_decim_irq.sv
module uflow_decim_irq #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_RELOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             mode_alt,
  input  logic             gate_en,
  input  logic             edge_fall,
  input  logic             uflow,
  input  logic             reload_ctl,
  input  logic             cfg_wr_valid,
  output logic             cfg_wr_ready,
  input  logic [CNT_W-1:0] cfg_wr_data,
  output logic             irq
);
  logic             count_evt;
  logic [CNT_W-1:0] reload_q;

  uflow_evt_qual u_qual (
    .clk(clk), .mode_alt(mode_alt), .gate_en(gate_en), .edge_fall(edge_fall),
    .uflow(uflow), .reload_ctl(reload_ctl), .count_evt(count_evt)
  );

  uflow_reload_reg #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_reload (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .wr_valid(cfg_wr_valid),
    .wr_ready(cfg_wr_ready), .wr_data(cfg_wr_data), .reload_q(reload_q)
  );

  uflow_decim_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .count_evt(count_evt),
    .reload_q(reload_q), .irq(irq)
  );
endmodule

// File: rtl/uflow_decim_irq_chk.sv
module uflow_decim_irq_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             func_en,
  input logic             mode_alt,
  input logic             gate_en,
  input logic             uflow,
  input logic             reload_ctl,
  input logic             cfg_wr_valid,
  input logic             cfg_wr_ready,
  input logic [CNT_W-1:0] cfg_wr_data,
  input logic             count_evt,
  input logic [CNT_W-1:0] reload_q,
  input logic             irq
);
  p_reload_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    func_en |=> $stable(reload_q));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && cfg_wr_ready) |=> (reload_q == $past(cfg_wr_data)));

  p_basic_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_alt && uflow) |-> count_evt);

  p_ungated_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_alt && !gate_en && uflow) |-> count_evt);

  p_gated_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_alt && gate_en && (reload_ctl == $past(reload_ctl))) |-> !count_evt);

  p_no_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> !irq);

  p_irq_from_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(count_evt && func_en));
endmodule

bind uflow_decim_irq uflow_decim_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .func_en(func_en), .mode_alt(mode_alt),
  .gate_en(gate_en), .uflow(uflow), .reload_ctl(reload_ctl),
  .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
  .cfg_wr_data(cfg_wr_data), .count_evt(count_evt), .reload_q(reload_q),
  .irq(irq)
);

// File: tb/uflow_decim_irq_bench.sv
module uflow_decim_irq_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_en = 1'b0, mode_alt = 1'b0, gate_en = 1'b0, edge_fall = 1'b0;
  logic uflow = 1'b0, reload_ctl = 1'b0, cfg_wr_valid = 1'b0;
  logic [CNT_W-1:0] cfg_wr_data = '0;
  logic cfg_wr_ready, irq;

  int checks = 0;
  int errors = 0;

  logic  exp_q[$];
  string tag_q[$];

  // bench reference state, built from the requirements
  logic b_en = 1'b0, b_alt = 1'b0, b_gate = 1'b0, b_fall = 1'b0, prev_c = 1'b0;
  int   b_n = 1;
  int   left = 0;

  always #4 clk = ~clk;

  uflow_decim_irq #(.CNT_W(CNT_W)) u_uflow_decim_irq (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .mode_alt(mode_alt),
    .gate_en(gate_en), .edge_fall(edge_fall), .uflow(uflow),
    .reload_ctl(reload_ctl), .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_ready(cfg_wr_ready), .cfg_wr_data(cfg_wr_data), .irq(irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int neff();
    return (b_n == 0) ? 1 : b_n;
  endfunction

  // monitor: compares irq just after each edge with the queued expectation
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(irq, e, t);
    end
  end

  task automatic tick(input logic u, input logic c, input string tag);
    logic ev, exp;
    @(negedge clk);
    uflow = u; reload_ctl = c; cfg_wr_valid = 1'b0;
    ev = (b_alt && b_gate) ? (b_fall ? (prev_c && !c) : (!prev_c && c)) : u;
    exp = 1'b0;
    if (b_en && ev) begin
      left--;
      if (left == 0) begin exp = 1'b1; left = neff(); end
    end
    prev_c = c;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic cfg_write(input int n);
    @(negedge clk);
    func_en = 1'b0; b_en = 1'b0; uflow = 1'b0;
    cfg_wr_valid = 1'b1; cfg_wr_data = CNT_W'(n);
    #1 check(cfg_wr_ready, 1'b1, "R2 ready while disabled");
    b_n = n;
    exp_q.push_back(1'b0); tag_q.push_back("R9");
  endtask

  task automatic set_mode(input logic alt, input logic gate, input logic fall);
    @(negedge clk);
    func_en = 1'b0; b_en = 1'b0; uflow = 1'b0; cfg_wr_valid = 1'b0;
    mode_alt = alt; gate_en = gate; edge_fall = fall;
    b_alt = alt; b_gate = gate; b_fall = fall;
    exp_q.push_back(1'b0); tag_q.push_back("R9");
  endtask

  task automatic arm(input logic u);
    @(negedge clk);
    func_en = 1'b1; b_en = 1'b1; uflow = u; cfg_wr_valid = 1'b0;
    left = (neff() == 1) ? 1 : neff() - 1;
    exp_q.push_back(1'b0); tag_q.push_back("R9 arm cycle");
  endtask

  task automatic disarm();
    @(negedge clk);
    func_en = 1'b0; b_en = 1'b0; uflow = 1'b0; cfg_wr_valid = 1'b0;
    exp_q.push_back(1'b0); tag_q.push_back("R9");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq, 1'b0, "R1 irq after reset");
    check(cfg_wr_ready, 1'b1, "R1 ready after reset");

    // R1: default reload of 1, one request per underflow
    arm(1'b0);
    for (int i = 0; i < 3; i++) begin tick(1'b1, 1'b0, "R1"); tick(1'b0, 1'b0, "R1"); end

    // R3 R7: basic mode with gate/edge bits set and reload_ctl wiggling
    set_mode(1'b0, 1'b1, 1'b1);
    cfg_write(3);
    arm(1'b0);
    for (int i = 0; i < 9; i++) begin
      tick(1'b1, i[0], "R3 R7");
      tick(1'b0, ~i[0], "R3");
    end

    // R2: write offered while running is back-pressured and ignored
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_data = 8'd5; uflow = 1'b0;
    #1 check(cfg_wr_ready, 1'b0, "R2 ready while enabled");
    exp_q.push_back(1'b0); tag_q.push_back("R2");
    for (int i = 0; i < 7; i++) begin tick(1'b1, 1'b0, "R2 period kept"); tick(1'b0, 1'b0, "R2"); end

    // R9: disabled means no counting and no request
    disarm();
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, "R9 disabled");

    // R4: alternate mode, gating off
    set_mode(1'b1, 1'b0, 1'b0);
    cfg_write(4);
    arm(1'b1);
    for (int i = 0; i < 11; i++) begin tick(1'b1, i[0], "R4 R7"); tick(1'b0, i[0], "R4"); end

    // R5: rising edges of reload_ctl, underflows ignored
    set_mode(1'b1, 1'b1, 1'b0);
    cfg_write(2);
    arm(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, "R5 uflow ignored");
    for (int i = 0; i < 6; i++) begin
      tick(1'b0, 1'b1, "R5 rise"); tick(1'b1, 1'b1, "R5"); tick(1'b0, 1'b0, "R5 fall ignored");
    end

    // R6: falling edges
    set_mode(1'b1, 1'b1, 1'b1);
    cfg_write(3);
    arm(1'b0);
    for (int i = 0; i < 8; i++) begin tick(1'b1, 1'b1, "R6 rise ignored"); tick(1'b0, 1'b0, "R6 fall"); end

    // R8: reload 1 and 0, underflow every cycle
    set_mode(1'b0, 1'b0, 1'b0);
    cfg_write(1);
    arm(1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, "R8 n=1");
    cfg_write(0);
    arm(1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, "R8 n=0");

    // R9 R10: event in the arm cycle is ignored; re-arm restarts period
    cfg_write(3);
    arm(1'b1);
    tick(1'b1, 1'b0, "R9 first counted");
    tick(1'b1, 1'b0, "R10 fires");
    tick(1'b0, 1'b0, "R10 single pulse");
    tick(1'b1, 1'b0, "R7");
    disarm();
    arm(1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, "R9 re-armed");
    disarm();
    tick(1'b0, 1'b0, "R9");
    @(negedge clk);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule